// File: doc/BRIEF.md
# Two-Channel Timer with Buffered PWM

A free-running up-counter wraps at a programmable modulo value and feeds two capture/compare channels. Each channel is idle, captures the counter on a rising input edge, toggles its output on a compare match, or generates PWM. In PWM mode the output goes high at counter overflow and low at the compare match. The counter advances only on cycles where the clock-enable input is high and the stop bit is clear.

Setting the pair bit in channel 0's configuration joins the two channels into one buffered PWM output on channel 0. The two value registers then take turns as the active duty value. A write to the idle one is switched in at the next overflow, so a partial update never reaches the pin. Overflow and channel events set sticky flags. A flag clears only when a read that saw it set is followed by a write of 0 to it, and an event in between keeps it set. While the wait input is high, host access is blocked, the counter keeps running, and any enabled request is driven on the wake output.

The register port is a 3-bit address with read and write strobes and reads that return in the same cycle. Address 0 is control: bit 0 stop, bit 1 overflow interrupt enable, bit 15 overflow flag. Address 1 is the modulo value. Address 2 is the counter, read-only. Addresses 3 and 5 are the configurations of channels 0 and 1: bits [1:0] mode (0 idle, 1 capture, 2 compare, 3 PWM), bit 2 overflow-set enable, bit 3 full-duty, bit 4 interrupt enable, bit 5 pair (honoured on channel 0 only), bit 15 event flag. Addresses 4 and 6 hold the channel values.

Top module: `dual_timer`

## Requirements
- R1: The counter resets to 0, advances by one on each cycle with en_i high and stop clear, and returns to 0 on the cycle after it equals the modulo value. The period is modulo+1 counts. A write to the modulo register clears the counter.
- R2: The overflow flag (address 0 bit 15) sets on each cycle where the counter wraps. irq_o follows it only while the overflow interrupt enable (bit 1) is 1.
- R3: A flag clears only when a read that saw it set is followed by a write of 0 to that bit. A write without such a read, or an event between the read and the write, leaves the flag set.
- R4: In PWM mode (mode 3) with bit 2 set, the output goes high after the overflow and low after the match. The high time is value+1 counts and the period is modulo+1 counts.
- R5: In PWM mode with bit 2 clear, the output is never set at overflow and is driven low at each match, giving a constant 0% duty.
- R6: In PWM mode with bits 2 and 3 both set, the output stays high (100% duty).
- R7: In compare mode (mode 2), the output toggles on each match and the channel flag sets. irq_o rises when the channel interrupt enable is 1.
- R8: In capture mode (mode 1), a rising edge on the channel's capture input copies the counter into the channel's value register and sets its flag, even while the counter is halted.
- R9: With channel 0 in PWM mode and its pair bit (bit 5) set, channel 0's configuration alone drives pwm_o[0]. pwm_o[1] is held low and channel 1's configuration raises no flag.
- R10: While paired, a write to the inactive value register changes the duty only from the next overflow. The active register then alternates between the two on each such update.
- R11: While wait_i is high, host reads return 0 and host writes have no effect. Counting continues, and wake_o is high whenever an enabled request is pending.
- R12: With the stop bit set, the counter and all outputs hold their levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Counter clock enable (prescaler tick) |
| wait_i | input | 1 | Wait mode: blocks host access |
| addr_i | input | 3 | Register address |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| wdata_i | input | CW | Write data |
| rdata_o | output | CW | Read data, same cycle as rd_i |
| cap_i | input | 2 | Capture inputs, one per channel |
| pwm_o | output | 2 | Channel outputs |
| irq_o | output | 1 | Any enabled flag set |
| wake_o | output | 1 | Enabled request while in wait mode |

## Verification
The bench goes after the flag-clear race. If a clear does not require a prior read, or an event between the read and the write does not re-protect the flag, the flag drops when it should stay set. It measures high time and period at several modulo and value settings. An off-by-one in the wrap or the match shows up as a pulse one count short or long. In buffered mode it writes the idle register in the middle of a high phase: a design that switches early shortens or lengthens that pulse, and one that does not alternate keeps the old duty on the second update. It also checks that writes in wait mode are dropped, that stop freezes a high output, and that channel 1 stays silent while paired.

// File: rtl/tim2_pkg.sv
package tim2_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    CH_IDLE = 2'd0,
    CH_CAPT = 2'd1,
    CH_COMP = 2'd2,
    CH_PWM  = 2'd3
  } ch_mode_e;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_MOD  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CFG0 = 3'd3;
  localparam logic [ADDR_W-1:0] A_VAL0 = 3'd4;
  localparam logic [ADDR_W-1:0] A_CFG1 = 3'd5;
  localparam logic [ADDR_W-1:0] A_VAL1 = 3'd6;
endpackage

// File: rtl/tim2_counter.sv
module tim2_counter #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          clr_i,
  input  logic [CW-1:0] mod_i,
  output logic [CW-1:0] cnt_o,
  output logic          ovf_o
);
  assign ovf_o = tick_i && (cnt_o == mod_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (ovf_o)  cnt_o <= '0;
    else if (tick_i) cnt_o <= cnt_o + 1'b1;
  end

  // R1
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= mod_i);

  // R12
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(cnt_o));
endmodule

// File: rtl/tim2_channel.sv
module tim2_channel import tim2_pkg::*; #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          ovf_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] cmp_i,
  input  ch_mode_e      mode_i,
  input  logic          tov_i,
  input  logic          maxd_i,
  input  logic          cap_i,
  output logic          out_o,
  output logic          evt_o,
  output logic          cap_evt_o
);
  logic cap_q;
  logic match;

  assign match     = tick_i && (cnt_i == cmp_i) && (mode_i == CH_COMP || mode_i == CH_PWM);
  assign cap_evt_o = (mode_i == CH_CAPT) && cap_i && !cap_q;
  assign evt_o     = match || cap_evt_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cap_q <= 1'b0;
    else         cap_q <= cap_i;
  end

  // overflow set wins over a match in the same cycle (value == modulo gives full duty)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_o <= 1'b0;
    end else if (mode_i == CH_PWM) begin
      if (ovf_i && tov_i) out_o <= 1'b1;
      else if (match)     out_o <= tov_i && maxd_i;
    end else if (mode_i == CH_COMP && match) begin
      out_o <= !out_o;
    end
  end

  // R5
  zero_duty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == CH_PWM && !tov_i && !out_o) |=> !out_o);

  // R6
  full_duty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == CH_PWM && tov_i && maxd_i && out_o) |=> out_o);
endmodule

// File: rtl/dual_timer.sv
module dual_timer import tim2_pkg::*; #(
  parameter int CW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wait_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [CW-1:0]     wdata_i,
  output logic [CW-1:0]     rdata_o,
  input  logic [1:0]        cap_i,
  output logic [1:0]        pwm_o,
  output logic              irq_o,
  output logic              wake_o
);
  localparam int NCH  = 2;
  localparam int FLAG = CW - 1;

  logic          host_wr, host_rd, tick, ovf, linked;
  logic [CW-1:0] cnt, mod_q;
  logic          stop_q, ovf_ie_q, ovf_flag_q, ovf_arm_q;
  logic          act_q, pend_q, wr_inact;

  ch_mode_e      mode_w  [NCH];
  logic          flag_w  [NCH];
  logic          ie_w    [NCH];
  logic          link_w  [NCH];
  logic [CW-1:0] val_w   [NCH];
  logic [CW-1:0] cfg_rd  [NCH];

  assign host_wr = wr_i && !wait_i;
  assign host_rd = rd_i && !wait_i;
  assign tick    = en_i && !stop_q;
  assign linked  = link_w[0] && (mode_w[0] == CH_PWM);

  tim2_counter #(.CW(CW)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick),
    .clr_i (host_wr && addr_i == A_MOD),
    .mod_i (mod_q),
    .cnt_o (cnt),
    .ovf_o (ovf)
  );

  // control, modulo and overflow flag
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_q     <= 1'b0;
      ovf_ie_q   <= 1'b0;
      ovf_flag_q <= 1'b0;
      ovf_arm_q  <= 1'b0;
      mod_q      <= '1;
    end else begin
      if (host_wr && addr_i == A_CTRL) begin
        stop_q   <= wdata_i[0];
        ovf_ie_q <= wdata_i[1];
      end
      if (host_wr && addr_i == A_MOD) mod_q <= wdata_i;
      if (ovf) ovf_flag_q <= 1'b1;
      else if (host_wr && addr_i == A_CTRL && ovf_arm_q && !wdata_i[FLAG]) ovf_flag_q <= 1'b0;
      if (ovf || (host_wr && addr_i == A_CTRL)) ovf_arm_q <= 1'b0;
      else if (host_rd && addr_i == A_CTRL && ovf_flag_q) ovf_arm_q <= 1'b1;
    end
  end

  // buffered pair: act_q selects the value register driving channel 0
  assign wr_inact = host_wr && linked && (addr_i == (act_q ? A_VAL0 : A_VAL1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (!linked) begin
      act_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (ovf && pend_q) begin
      act_q  <= !act_q;
      pend_q <= 1'b0;
    end else if (wr_inact) begin
      pend_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_CFG = A_CFG0 + ADDR_W'(2 * g);
    localparam logic [ADDR_W-1:0] A_VAL = A_VAL0 + ADDR_W'(2 * g);

    ch_mode_e      mode_r, mode_eff;
    logic          tov_r, maxd_r, ie_r, link_r, flag_r, arm_r;
    logic [CW-1:0] val_r, cmp_eff;
    logic          out, evt, cap_evt, wr_cfg;

    assign wr_cfg   = host_wr && addr_i == A_CFG;
    assign mode_eff = (g == 1 && linked) ? CH_IDLE : mode_r;
    assign cmp_eff  = (g == 0 && linked) ? (act_q ? val_w[1] : val_w[0]) : val_r;

    tim2_channel #(.CW(CW)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick),
      .ovf_i    (ovf),
      .cnt_i    (cnt),
      .cmp_i    (cmp_eff),
      .mode_i   (mode_eff),
      .tov_i    (tov_r),
      .maxd_i   (maxd_r),
      .cap_i    (cap_i[g]),
      .out_o    (out),
      .evt_o    (evt),
      .cap_evt_o(cap_evt)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mode_r <= CH_IDLE;
        tov_r  <= 1'b0;
        maxd_r <= 1'b0;
        ie_r   <= 1'b0;
        link_r <= 1'b0;
        flag_r <= 1'b0;
        arm_r  <= 1'b0;
        val_r  <= '0;
      end else begin
        if (wr_cfg) begin
          mode_r <= ch_mode_e'(wdata_i[1:0]);
          tov_r  <= wdata_i[2];
          maxd_r <= wdata_i[3];
          ie_r   <= wdata_i[4];
          link_r <= wdata_i[5];
        end
        if (cap_evt) val_r <= cnt;
        else if (host_wr && addr_i == A_VAL) val_r <= wdata_i;
        if (evt) flag_r <= 1'b1;
        else if (wr_cfg && arm_r && !wdata_i[FLAG]) flag_r <= 1'b0;
        if (evt || wr_cfg) arm_r <= 1'b0;
        else if (host_rd && addr_i == A_CFG && flag_r) arm_r <= 1'b1;
      end
    end

    assign mode_w[g] = mode_r;
    assign flag_w[g] = flag_r;
    assign ie_w[g]   = ie_r;
    assign link_w[g] = link_r;
    assign val_w[g]  = val_r;
    assign cfg_rd[g] = {flag_r, {(CW-7){1'b0}}, link_r, ie_r, maxd_r, tov_r, mode_r};
    assign pwm_o[g]  = (g == 1 && linked) ? 1'b0 : out;

    if (g == 1) begin : g_pair_chk
      // R9
      pair_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (linked && !flag_r) |=> !flag_r);
    end
  end

  always_comb begin
    rdata_o = '0;
    if (host_rd) begin
      case (addr_i)
        A_CTRL: begin
          rdata_o[0]    = stop_q;
          rdata_o[1]    = ovf_ie_q;
          rdata_o[FLAG] = ovf_flag_q;
        end
        A_MOD:  rdata_o = mod_q;
        A_CNT:  rdata_o = cnt;
        A_CFG0: rdata_o = cfg_rd[0];
        A_VAL0: rdata_o = val_w[0];
        A_CFG1: rdata_o = cfg_rd[1];
        A_VAL1: rdata_o = val_w[1];
        default: rdata_o = '0;
      endcase
    end
  end

  always_comb begin
    irq_o = ovf_flag_q && ovf_ie_q;
    for (int i = 0; i < NCH; i++) irq_o = irq_o || (flag_w[i] && ie_w[i]);
  end

  assign wake_o = wait_i && irq_o;

  // R2
  ovf_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf |=> ovf_flag_q);

  // R3
  flag_clear_needs_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_flag_q && !(ovf_arm_q && wr_i && addr_i == A_CTRL)) |=> ovf_flag_q);

  // R10
  act_swap_at_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (linked && !ovf) |=> $stable(act_q));

  // R11
  wait_blocks_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_i && wr_i) |=> $stable(mod_q));
endmodule

// File: tb/dual_timer_bench.sv
module dual_timer_bench;
  import tim2_pkg::*;
  localparam int CW = 16;

  logic          clk = 1'b0, rst_ni = 1'b0, en_i = 1'b0, wait_i = 1'b0;
  logic          wr_i = 1'b0, rd_i = 1'b0;
  logic [2:0]    addr_i = '0;
  logic [CW-1:0] wdata_i = '0;
  logic [CW-1:0] rdata_o;
  logic [1:0]    cap_i = '0;
  logic [1:0]    pwm_o;
  logic          irq_o, wake_o;
  int            n_chk = 0, n_bad = 0;

  // {modulo, value, expected high, expected period}
  localparam logic [63:0] VEC [4] = '{
    {16'd9,  16'd3,  16'd4,  16'd10},
    {16'd9,  16'd0,  16'd1,  16'd10},
    {16'd15, 16'd10, 16'd11, 16'd16},
    {16'd4,  16'd2,  16'd3,  16'd5}
  };

  always #2 clk = ~clk;

  dual_timer #(.CW(CW)) u_dual_timer (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .wait_i(wait_i),
    .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .cap_i(cap_i), .pwm_o(pwm_o),
    .irq_o(irq_o), .wake_o(wake_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [CW-1:0] d);
    @(negedge clk); addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk); wr_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [CW-1:0] d);
    @(negedge clk); addr_i = a; rd_i = 1'b1;
    #1 d = rdata_o;
    @(negedge clk); rd_i = 1'b0;
  endtask

  // waits for a rising edge, optionally writes on that cycle, measures high time and period
  task automatic pulse(input int ch, input bit do_wr, input logic [2:0] a, input logic [CW-1:0] d,
                       output int hi, output int per);
    logic prev, rise;
    int lim;
    lim = 0;
    @(negedge clk); prev = pwm_o[ch];
    do begin
      @(negedge clk); lim++;
      rise = pwm_o[ch] && !prev; prev = pwm_o[ch];
    end while (!rise && lim < 4000);
    if (do_wr) begin addr_i = a; wdata_i = d; wr_i = 1'b1; end
    hi = 1; per = 1;
    do begin
      @(negedge clk); wr_i = 1'b0; lim++;
      rise = pwm_o[ch] && !prev; prev = pwm_o[ch];
      if (!rise) begin per++; if (pwm_o[ch]) hi++; end
    end while (!rise && lim < 8000);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [CW-1:0] v, a0;
    int hi, per, cnt_hi;

    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // reset state
    rd(A_MOD, v); chk(v == 16'hFFFF, "R1 reset modulo", v, 16'hFFFF);
    rd(A_CNT, v); chk(v == 0, "R1 reset count", v, 0);
    chk(pwm_o == 2'b00, "R4 reset outputs", pwm_o, 0);
    chk(irq_o == 0 && wake_o == 0, "R2 reset irq", irq_o, 0);

    // R1 counting gated by en_i, wrap at modulo
    wr(A_MOD, 16'd9);
    rd(A_CNT, v); chk(v == 0, "R1 modulo write clears count", v, 0);
    en_i = 1'b1; repeat (7) @(negedge clk); en_i = 1'b0;
    rd(A_CNT, v); chk(v == 7, "R1 count after 7 ticks", v, 7);
    en_i = 1'b1; repeat (5) @(negedge clk); en_i = 1'b0;
    rd(A_CNT, v); chk(v == 2, "R1 wrap period modulo+1", v, 2);

    // R2 overflow flag and enable
    chk(irq_o == 0, "R2 irq masked while enable clear", irq_o, 0);
    wr(A_CTRL, 16'h0002);
    chk(irq_o == 1, "R2 irq after enable set", irq_o, 1);
    rd(A_CTRL, v); chk(v[15] == 1, "R3 write without read keeps flag", v[15], 1);
    wr(A_CTRL, 16'h0002);
    rd(A_CTRL, v); chk(v[15] == 0, "R3 read then write 0 clears", v[15], 0);
    chk(irq_o == 0, "R2 irq drops with flag", irq_o, 0);

    // R3 event between read and write
    en_i = 1'b1; repeat (12) @(negedge clk); en_i = 1'b0;
    rd(A_CTRL, v); chk(v[15] == 1, "R2 flag set on wrap", v[15], 1);
    en_i = 1'b1; repeat (12) @(negedge clk); en_i = 1'b0;
    wr(A_CTRL, 16'h0002);
    rd(A_CTRL, v); chk(v[15] == 1, "R3 event between read and write keeps flag", v[15], 1);
    wr(A_CTRL, 16'h0002);
    rd(A_CTRL, v); chk(v[15] == 0, "R3 flag cleared", v[15], 0);

    // R11 wait mode
    en_i = 1'b1; wait_i = 1'b1;
    repeat (12) @(negedge clk);
    chk(wake_o == 1, "R11 counting and wake in wait", wake_o, 1);
    rd(A_MOD, v); chk(v == 0, "R11 read blocked in wait", v, 0);
    wr(A_MOD, 16'd3);
    wait_i = 1'b0; #1;
    chk(wake_o == 0, "R11 wake only in wait", wake_o, 0);
    rd(A_MOD, v); chk(v == 9, "R11 write ignored in wait", v, 9);

    // R12 stop holds counter, R8 capture
    wr(A_CTRL, 16'h0001);
    rd(A_CNT, a0);
    repeat (5) @(negedge clk);
    rd(A_CNT, v); chk(v == a0, "R12 counter held by stop", v, a0);
    wr(A_CFG1, 16'h0011);
    @(negedge clk); cap_i[1] = 1'b1;
    @(negedge clk); cap_i[1] = 1'b0;
    rd(A_VAL1, v); chk(v == a0, "R8 captured count", v, a0);
    rd(A_CFG1, v); chk(v[15] == 1, "R8 capture sets flag", v[15], 1);
    wr(A_CFG1, 16'h0000);

    // R4 PWM table
    for (int i = 0; i < 4; i++) begin
      wr(A_CTRL, 16'h0001);
      wr(A_CFG0, 16'h0007);
      wr(A_VAL0, VEC[i][47:32]);
      wr(A_MOD, VEC[i][63:48]);
      wr(A_CTRL, 16'h0000);
      pulse(0, 1'b0, A_CTRL, '0, hi, per);
      chk(hi == int'(VEC[i][31:16]), "R4 high time", hi, int'(VEC[i][31:16]));
      chk(per == int'(VEC[i][15:0]), "R4 period", per, int'(VEC[i][15:0]));
    end

    // R12 output held high across stop
    wr(A_CTRL, 16'h0001);
    repeat (10) @(negedge clk);
    chk(pwm_o[0] == 1, "R12 output held by stop", pwm_o[0], 1);

    // R5 zero duty
    wr(A_CFG0, 16'h0003);
    wr(A_VAL0, 16'd3);
    wr(A_MOD, 16'd9);
    wr(A_CTRL, 16'h0000);
    repeat (25) @(negedge clk);
    cnt_hi = 0;
    for (int k = 0; k < 20; k++) begin @(negedge clk); if (pwm_o[0]) cnt_hi++; end
    chk(cnt_hi == 0, "R5 zero duty high samples", cnt_hi, 0);

    // R6 full duty
    wr(A_CFG0, 16'h000F);
    repeat (25) @(negedge clk);
    cnt_hi = 0;
    for (int k = 0; k < 20; k++) begin @(negedge clk); if (pwm_o[0]) cnt_hi++; end
    chk(cnt_hi == 20, "R6 full duty high samples", cnt_hi, 20);

    // R9 / R10 paired buffered PWM
    wr(A_CTRL, 16'h0001);
    wr(A_CFG1, 16'h0012);
    wr(A_VAL0, 16'd3);
    wr(A_VAL1, 16'd5);
    wr(A_MOD, 16'd9);
    wr(A_CFG0, 16'h0027);
    wr(A_CTRL, 16'h0000);
    pulse(0, 1'b0, A_CTRL, '0, hi, per);
    chk(hi == 4, "R9 paired output from channel 0 value", hi, 4);
    chk(pwm_o[1] == 0, "R9 channel 1 output held low", pwm_o[1], 0);
    pulse(0, 1'b1, A_VAL1, 16'd6, hi, per);
    chk(hi == 4, "R10 inactive write not applied mid-period", hi, 4);
    chk(per == 10, "R10 period unchanged", per, 10);
    pulse(0, 1'b0, A_CTRL, '0, hi, per);
    chk(hi == 7, "R10 new duty after overflow", hi, 7);
    pulse(0, 1'b1, A_VAL0, 16'd1, hi, per);
    chk(hi == 7, "R10 second update waits for overflow", hi, 7);
    pulse(0, 1'b0, A_CTRL, '0, hi, per);
    chk(hi == 2, "R10 active register alternates", hi, 2);
    rd(A_CFG1, v); chk(v[15] == 0, "R9 channel 1 raises no flag", v[15], 0);

    // R7 compare toggle on channel 1
    wr(A_CTRL, 16'h0001);
    wr(A_CFG0, 16'h0007);
    wr(A_CTRL, 16'h0000);
    pulse(1, 1'b0, A_CTRL, '0, hi, per);
    chk(hi == 10, "R7 toggle high span", hi, 10);
    chk(per == 20, "R7 toggle period", per, 20);
    rd(A_CFG1, v); chk(v[15] == 1, "R7 compare sets flag", v[15], 1);
    chk(irq_o == 1, "R7 channel irq", irq_o, 1);

    finish_run();
  end
endmodule